// File: doc/BRIEF.md
# Memory-mapped flash read cache

The block answers 32-bit reads from a memory-mapped serial flash window. It keeps one 1024-byte line of flash content and the window address where that line starts. A read that falls inside the line is served from the line buffer, with no serial traffic. A read outside the line starts a refill. The block selects one flash chip and sends a read command header over a byte-exchange handshake toward a SPI shifter. The header is an opcode, a 24-bit address, an optional mode byte and a number of zero dummy bytes. The block then clocks in 1024 data bytes and packs them into 256 words. When the line is full it releases the chip select, records the new line start and answers the pending read from the buffer.

A 32-bit configuration register sets the header contents and the address scaling. When two flash memories sit on separate buses, the window address is halved before it goes to the flash. The flash address bits from bit 24 upward pick the chip. Serial clocking and multi-lane transfers belong to the shifter beyond the byte-exchange handshake.

Top module: `flash_line_cache`

## Requirements
- R1: After reset `cfg_q` reads 0x03A002EB, every `cs_n` bit is high, `req_ready` is 1 and `resp_valid` is 0. No line is held, so the first read always refills.
- R2: A read is a hit when the line is valid and base ≤ addr ≤ base + 1020 (addresses word aligned). The hit returns word (addr − base)/4 of the line with `resp_valid` high in the cycle after acceptance, and it performs no byte exchange.
- R3: A read below base or above base + 1020 starts a refill.
- R4: The refill header starts with the opcode cfg[7:0], followed by flash address bits 23:16, 15:8 and 7:0 in that order. `xfer_tx` holds steady while `xfer_valid` waits for `xfer_ready`.
- R5: When cfg[25] is 1, the mode byte cfg[23:16] follows the address. Then cfg[10:8] dummy bytes of value 0x00 are sent.
- R6: After the header come exactly 1024 exchanges with `xfer_tx` = 0x00, and bytes received during the header are dropped. With `big_endian` = 0, byte i of each group of four lands in word bits 8i+7:8i.
- R7: With `big_endian` = 1, sampled when the miss is accepted, byte 0 of each group lands in bits 31:24 and byte 3 in bits 7:0.
- R8: The flash address equals the request address shifted right by one when cfg[30] and cfg[29] are both 1. Otherwise the flash address equals the request address.
- R9: The chip index is flash address bits ADDR_W−1:24. `cs_n[index]` goes low for the whole refill, no other bit goes low, and all bits are high whenever the block is idle.
- R10: After the last data byte the line base becomes the request address. The read is answered with line word 0 two cycles after the last exchange.
- R11: While a refill runs, `req_ready` stays low. A request held on the port during the refill is not accepted before the answer to the refilling read.
- R12: The header, address scaling, chip and byte order come from the configuration as it stood before the acceptance edge. A register write on that same edge affects only later misses.
- R13: When `cfg_we` is 1, `cfg_wdata` appears on `cfg_q` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Window byte address of the read |
| req_ready | output | 1 | Request accepted on this edge when valid |
| resp_valid | output | 1 | Read data valid, one cycle per read |
| resp_data | output | 32 | Read data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_q | output | 32 | Current configuration |
| big_endian | input | 1 | Byte order for packing received data |
| cs_n | output | NUM_CS | Active-low flash chip selects |
| xfer_valid | output | 1 | Byte exchange requested |
| xfer_tx | output | 8 | Byte to send |
| xfer_ready | input | 1 | Exchange completes on this edge |
| xfer_rx | input | 8 | Byte received, valid with xfer_ready |

## Verification
A configuration write and the acceptance of a missing read can fall on the same clock edge. The bench provokes this by raising `cfg_we` with a new opcode in the same cycle as a read outside the line. It then checks that the header the flash model logs still carries the previous opcode and address scaling, while `cfg_q` already shows the new value. The next miss is then checked to carry the new opcode. A second overlap is a new request presented while a refill runs. The bench holds one on the port and judges by `req_ready` staying low on every refill cycle and by no second answer or refill following.

// File: rtl/flash_line_cache.sv
module flash_line_cache #(
  parameter int          ADDR_W     = 26,
  parameter int          NUM_CS     = 2,
  parameter int          LINE_BYTES = 1024,
  parameter logic [31:0] CFG_RESET  = 32'h03A002EB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [31:0]       resp_data,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_q,
  input  logic              big_endian,
  output logic [NUM_CS-1:0] cs_n,
  output logic              xfer_valid,
  output logic [7:0]        xfer_tx,
  input  logic              xfer_ready,
  input  logic [7:0]        xfer_rx
);
  localparam int WORDS  = LINE_BYTES / 4;
  localparam int IDX_W  = $clog2(WORDS);
  localparam int BCNT_W = $clog2(LINE_BYTES);
  localparam int CHIP_W = ADDR_W - 24;
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(LINE_BYTES - 4);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_DATA, S_DONE} state_t;

  state_t              state;
  logic [31:0]         cfg_r;
  logic [ADDR_W-1:0]   base_q, addr_q;
  logic                base_ok;
  logic [23:0]         fa_q;
  logic [7:0]          op_q, mode_q, hdr_byte;
  logic                mode_en_q, big_q;
  logic [3:0]          hlen_q, hcnt;
  logic [BCNT_W-1:0]   bcnt;
  logic [1:0]          lane;
  logic [31:0]         word_q, word_nx;
  logic [31:0]         line [WORDS];
  logic [ADDR_W:0]     diff;
  logic                hit, fire, done;
  logic [IDX_W-1:0]    idx;
  logic [ADDR_W-1:0]   fa_nx;
  logic [CHIP_W-1:0]   chip_nx;
  logic [NUM_CS-1:0]   sel_nx;

  assign cfg_q      = cfg_r;
  assign diff       = {1'b0, req_addr} - {1'b0, base_q};
  assign hit        = base_ok && !diff[ADDR_W] && (diff[ADDR_W-1:0] <= SPAN);
  assign idx        = diff[IDX_W+1:2];
  assign fa_nx      = (cfg_r[30] && cfg_r[29]) ? (req_addr >> 1) : req_addr;
  assign chip_nx    = fa_nx[ADDR_W-1:24];
  assign req_ready  = (state == S_IDLE);
  assign fire       = req_valid && req_ready;
  assign xfer_valid = (state == S_HDR) || (state == S_DATA);
  assign done       = xfer_valid && xfer_ready;
  assign xfer_tx    = (state == S_HDR) ? hdr_byte : 8'h00;
  assign lane       = big_q ? ~bcnt[1:0] : bcnt[1:0];

  for (genvar c = 0; c < NUM_CS; c++) begin : g_sel
    assign sel_nx[c] = (chip_nx == CHIP_W'(c));
  end

  logic unused_bits;
  assign unused_bits = ^{cfg_r[31], cfg_r[28:26], cfg_r[24], cfg_r[15:11]};

  always_comb begin
    case (hcnt)
      4'd0:    hdr_byte = op_q;
      4'd1:    hdr_byte = fa_q[23:16];
      4'd2:    hdr_byte = fa_q[15:8];
      4'd3:    hdr_byte = fa_q[7:0];
      4'd4:    hdr_byte = mode_en_q ? mode_q : 8'h00;
      default: hdr_byte = 8'h00;
    endcase
  end

  always_comb begin
    word_nx = word_q;
    word_nx[8*lane +: 8] = xfer_rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_r <= CFG_RESET;
    else if (cfg_we) cfg_r <= cfg_wdata;
  end

  always_ff @(posedge clk) begin
    if (state == S_DATA && done && bcnt[1:0] == 2'b11)
      line[bcnt[BCNT_W-1:2]] <= word_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      base_q     <= '0;
      base_ok    <= 1'b0;
      addr_q     <= '0;
      fa_q       <= '0;
      op_q       <= '0;
      mode_q     <= '0;
      mode_en_q  <= 1'b0;
      big_q      <= 1'b0;
      hlen_q     <= '0;
      hcnt       <= '0;
      bcnt       <= '0;
      word_q     <= '0;
      cs_n       <= '1;
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        S_IDLE: if (fire) begin
          if (hit) begin
            resp_valid <= 1'b1;
            resp_data  <= line[idx];
          end else begin
            addr_q    <= req_addr;
            fa_q      <= fa_nx[23:0];
            op_q      <= cfg_r[7:0];
            mode_q    <= cfg_r[23:16];
            mode_en_q <= cfg_r[25];
            big_q     <= big_endian;
            hlen_q    <= 4'd4 + 4'(cfg_r[25]) + 4'(cfg_r[10:8]);
            hcnt      <= '0;
            cs_n      <= ~sel_nx;
            state     <= S_HDR;
          end
        end
        S_HDR: if (done) begin
          if (hcnt == hlen_q - 4'd1) begin
            state <= S_DATA;
            bcnt  <= '0;
          end else begin
            hcnt <= hcnt + 4'd1;
          end
        end
        S_DATA: if (done) begin
          word_q <= word_nx;
          bcnt   <= bcnt + 1'b1;
          if (bcnt == BCNT_W'(LINE_BYTES - 1)) begin
            state   <= S_DONE;
            cs_n    <= '1;
            base_q  <= addr_q;
            base_ok <= 1'b1;
          end
        end
        default: begin
          resp_valid <= 1'b1;
          resp_data  <= line[0];
          state      <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_line_cache_chk.sv
module flash_line_cache_chk #(
  parameter int          NUM_CS    = 2,
  parameter logic [31:0] CFG_RESET = 32'h03A002EB
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic [31:0]       cfg_q,
  input logic [NUM_CS-1:0] cs_n,
  input logic              xfer_valid,
  input logic              xfer_ready,
  input logic [7:0]        xfer_tx
);
  assert_cfg_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> cfg_q == CFG_RESET);

  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_tx)));

  assert_cs_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_cs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && $past(xfer_valid)) |-> $stable(cs_n));

  assert_cs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&cs_n));

  assert_resp_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(req_valid && req_ready) || $past(xfer_valid, 2)));

  assert_ready_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> !req_ready);
endmodule

bind flash_line_cache flash_line_cache_chk #(.NUM_CS(NUM_CS), .CFG_RESET(CFG_RESET)) chk_i (.*);

// File: tb/flash_line_cache_tb.sv
`timescale 1ns/1ps
module flash_line_cache_tb_top;
  localparam int AW = 26;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready, resp_valid;
  logic [31:0]   resp_data, cfg_q;
  logic          cfg_we = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic          big_endian = 1'b0;
  logic [1:0]    cs_n;
  logic          xfer_valid;
  logic [7:0]    xfer_tx;
  logic          xfer_ready;
  logic [7:0]    xfer_rx;

  always #5 clk = ~clk;

  flash_line_cache #(.ADDR_W(AW), .NUM_CS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .big_endian(big_endian), .cs_n(cs_n), .xfer_valid(xfer_valid),
    .xfer_tx(xfer_tx), .xfer_ready(xfer_ready), .xfer_rx(xfer_rx));

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  int in_sess = 0, n_sess = 0, sessions = 0, cs_bad = 0, tx_bad = 0;
  int hdr_len_exp = 4;
  logic [1:0] sess_cs = 2'b11;
  logic [7:0] hlog [16];

  logic [AW-1:0] cur_base;
  int cur_bus, cur_chip;
  logic cur_big;
  int ready_bad, lat;

  function automatic logic [7:0] pat(input int chip, input logic [23:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ a[23:16] ^ ((chip != 0) ? 8'hC3 : 8'h00);
  endfunction

  function automatic logic [31:0] exp_word(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                           input int bus, input int chip, input logic big);
    logic [AW-1:0] fb, off;
    logic [7:0] by [4];
    fb  = (bus == 2) ? (b >> 1) : b;
    off = a - b;
    for (int i = 0; i < 4; i++) by[i] = pat(chip, fb[23:0] + off[23:0] + 24'(i));
    return big ? {by[0], by[1], by[2], by[3]} : {by[3], by[2], by[1], by[0]};
  endfunction

  initial begin
    xfer_ready = 1'b0;
    xfer_rx = 8'h00;
    forever begin
      @(negedge clk);
      if (&cs_n) in_sess = 0;
      if (xfer_ready) begin
        xfer_ready = 1'b0;
      end else if (xfer_valid) begin
        if (in_sess == 0) begin
          in_sess = 1; n_sess = 0; sess_cs = cs_n; sessions++;
        end
        if (cs_n != sess_cs) cs_bad++;
        if (n_sess < 16) hlog[n_sess] = xfer_tx;
        if (n_sess >= hdr_len_exp && xfer_tx != 8'h00) tx_bad++;
        if (n_sess < hdr_len_exp) xfer_rx = 8'hFF;
        else xfer_rx = pat((sess_cs == 2'b01) ? 1 : 0,
                           {hlog[1], hlog[2], hlog[3]} + 24'(n_sess - hdr_len_exp));
        n_sess++;
        xfer_ready = 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input bit hold, input logic [AW-1:0] a2,
                    input bit wcfg, input logic [31:0] wval, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    if (wcfg) begin cfg_we = 1'b1; cfg_wdata = wval; end
    @(negedge clk);
    cfg_we = 1'b0;
    if (hold) req_addr = a2; else req_valid = 1'b0;
    lat = 1; ready_bad = 0;
    while (!resp_valid && lat < 5000) begin
      if (req_ready) ready_bad++;
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    d = resp_data;
  endtask

  task automatic wr_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R13 cfg write", cfg_q, v);
  endtask

  task automatic miss_read(input string tag, input logic [AW-1:0] a, input logic [7:0] op,
                           input bit men, input logic [7:0] mb, input int dum,
                           input int bus, input int chip, input bit big,
                           input bit hold, input bit wcfg, input logic [31:0] wval);
    logic [AW-1:0] fa;
    logic [7:0] e [16];
    logic [31:0] d;
    int k, s0;
    fa = (bus == 2) ? (a >> 1) : a;
    e[0] = op; e[1] = fa[23:16]; e[2] = fa[15:8]; e[3] = fa[7:0];
    k = 4;
    if (men) begin e[4] = mb; k = 5; end
    for (int i = 0; i < dum; i++) e[k + i] = 8'h00;
    k = k + dum;
    hdr_len_exp = k;
    big_endian = big;
    s0 = sessions; cs_bad = 0; tx_bad = 0;
    rd(a, hold, a + 26'h4, wcfg, wval, d);
    chk({tag, " R3 refill started"}, 32'(sessions - s0), 32'd1);
    chk({tag, " R11 ready low in refill"}, 32'(ready_bad), 32'd0);
    chk({tag, " R6 exchange count"}, 32'(n_sess), 32'(k + 1024));
    chk({tag, " R6 data tx zero"}, 32'(tx_bad), 32'd0);
    chk({tag, " R9 chip select"}, {30'd0, sess_cs}, {30'd0, ~(2'b01 << chip)});
    chk({tag, " R9 select held"}, 32'(cs_bad), 32'd0);
    for (int i = 0; i < k; i++)
      chk($sformatf("%s R4 R5 header byte %0d", tag, i), {24'd0, hlog[i]}, {24'd0, e[i]});
    chk({tag, big ? " R7 data" : " R10 data"}, d, exp_word(a, a, bus, chip, big));
    chk({tag, " R9 released"}, {30'd0, cs_n}, 32'd3);
    cur_base = a; cur_bus = bus; cur_chip = chip; cur_big = big;
    if (hold) begin
      @(negedge clk);
      chk({tag, " R11 held request not taken"}, {31'd0, resp_valid}, 32'd0);
      chk({tag, " R11 no extra refill"}, 32'(sessions - s0), 32'd1);
    end
  endtask

  task automatic hit_read(input string tag, input logic [AW-1:0] a);
    logic [31:0] d;
    int s0;
    s0 = sessions;
    rd(a, 1'b0, '0, 1'b0, '0, d);
    chk({tag, " R2 no exchange"}, 32'(sessions - s0), 32'd0);
    chk({tag, " R2 latency"}, 32'(lat), 32'd1);
    chk({tag, " R2 data"}, d, exp_word(a, cur_base, cur_bus, cur_chip, cur_big));
  endtask

  task automatic t_reset;
    chk("R1 cfg reset", cfg_q, 32'h03A002EB);
    chk("R1 cs idle", {30'd0, cs_n}, 32'd3);
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    chk("R1 resp idle", {31'd0, resp_valid}, 32'd0);
  endtask

  task automatic t_default_miss;
    miss_read("R1 first", 26'h100, 8'hEB, 1, 8'hA0, 2, 1, 0, 0, 0, 0, '0);
  endtask

  task automatic t_hits;
    hit_read("R2 next", 26'h104);
    hit_read("R2 top", 26'h4FC);
    hit_read("R2 mid", 26'h300);
    hit_read("R2 base", 26'h100);
  endtask

  task automatic t_window_edges;
    miss_read("R3 above", 26'h500, 8'hEB, 1, 8'hA0, 2, 1, 0, 0, 0, 0, '0);
    miss_read("R3 below", 26'h4FC, 8'hEB, 1, 8'hA0, 2, 1, 0, 0, 0, 0, '0);
    hit_read("R3 after below", 26'h8F8);
  endtask

  task automatic t_headers;
    wr_cfg(32'h0000010B);
    miss_read("R5 no mode", 26'h2000, 8'h0B, 0, 8'h00, 1, 1, 0, 0, 0, 0, '0);
    wr_cfg(32'h025A0003);
    miss_read("R5 mode no dummy", 26'h3000, 8'h03, 1, 8'h5A, 0, 1, 0, 1, 0, 0, '0);
    hit_read("R7 big hit", 26'h3010);
  endtask

  task automatic t_busses;
    wr_cfg(32'h60000003);
    miss_read("R8 two bus", 26'h2000200, 8'h03, 0, 8'h00, 0, 2, 1, 0, 0, 0, '0);
    hit_read("R8 two bus hit", 26'h2000300);
    wr_cfg(32'h40000003);
    miss_read("R8 one bit", 26'h1000400, 8'h03, 0, 8'h00, 0, 1, 1, 0, 0, 0, '0);
    miss_read("R9 chip0", 26'h0000800, 8'h03, 0, 8'h00, 0, 1, 0, 0, 0, 0, '0);
  endtask

  task automatic t_same_edge_cfg;
    miss_read("R12 same edge", 26'h8000, 8'h03, 0, 8'h00, 0, 1, 0, 0, 0, 1, 32'h000000BB);
    chk("R12 new cfg visible", cfg_q, 32'h000000BB);
    miss_read("R12 next miss", 26'h9000, 8'hBB, 0, 8'h00, 0, 1, 0, 0, 0, 0, '0);
  endtask

  task automatic t_holdoff;
    miss_read("R11 holdoff", 26'hC000, 8'hBB, 0, 8'h00, 0, 1, 0, 0, 1, 0, '0);
    hit_read("R11 after", 26'hC004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_miss();
    t_hits();
    t_window_edges();
    t_headers();
    t_busses();
    t_same_edge_cfg();
    t_holdoff();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule